// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address to a physical address after a lookup miss in an upstream translation cache. It is started with a virtual address and a table base value, fetches the first-level descriptor from memory with a single word read, and either finishes there or performs a second word read from a coarse second-level table. The descriptor type bits select the mapping size, which is one of four: a 1 MB section, a 16 MB supersection, a 4 KB page or a 64 KB page.

When the walk finishes, the block pulses `walkDone` for one cycle. Along with that pulse it presents the physical address, a size code, the attribute bits of the final descriptor (the domain comes from the first-level descriptor), and a fault indication if the walk failed. A disable input forbids any memory access, and a start made while it is set ends at once in a section fault. Translation storage, permission checks and caching belong to other blocks.

Top module: `ptw_top`

## Requirements
- R1: After reset `walkDone` and `memReq` are low, and the walker accepts `walkStart` in its idle state.
- R2: The first-level read address is `ttbBase[31:14]`, followed by `va[31:20]`, followed by two zero bits.
- R3: A first-level descriptor with bits[1:0]=2'b10 and bit18=0 finishes after one read as a 1 MB section: `paddr = {desc[31:20], va[19:0]}` and `sizeCode = 0`.
- R4: A first-level descriptor with bits[1:0]=2'b10 and bit18=1 finishes after one read as a 16 MB supersection: `paddr = {desc[31:24], va[23:0]}` and `sizeCode = 1`.
- R5: A first-level descriptor with bits[1:0]=2'b01 leads to a second read at address `{desc[31:10], va[19:12], 2'b00}`.
- R6: A second-level descriptor with bits[1:0] equal to 2'b10 or 2'b11 gives a 4 KB page: `paddr = {desc[31:12], va[11:0]}` and `sizeCode = 2`.
- R7: A second-level descriptor with bits[1:0]=2'b01 gives a 64 KB page: `paddr = {desc[31:16], va[15:0]}` and `sizeCode = 3`.
- R8: A first-level descriptor with bits[1:0] equal to 2'b00 or 2'b11 gives a section fault (`fault=1`, `faultCode=1`). A second-level descriptor with bits[1:0]=2'b00 gives a page fault (`fault=1`, `faultCode=2`). A walk that does not fault reports `faultCode=0`.
- R9: When `walkDisable` is high at start, no `memReq` is raised and a section fault (`faultCode=1`) is returned.
- R10: While `memReq` is high and `memGnt` is low, `memReq` and `memAddr` hold their values. `walkDone` is high for exactly one cycle for each walk.
- R11: `domain` is taken from bits[8:5] of the first-level descriptor. `attr` is bits[11:2] of the descriptor that ends the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| walkStart | input | 1 | Start a walk; taken only when idle |
| va | input | 32 | Virtual address to translate |
| ttbBase | input | 32 | Translation table base value |
| walkDisable | input | 1 | Forbid the table walk and force a section fault |
| walkBusy | output | 1 | High while a walk is in progress |
| memReq | output | 1 | Word read request |
| memAddr | output | 32 | Word read address |
| memGnt | input | 1 | Request accepted this cycle |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data |
| walkDone | output | 1 | One-cycle pulse when the result is valid |
| paddr | output | 32 | Physical address |
| sizeCode | output | 2 | 0 = 1 MB, 1 = 16 MB, 2 = 4 KB, 3 = 64 KB |
| domain | output | 4 | Domain field from the first-level descriptor |
| attr | output | 10 | Descriptor bits [11:2] of the final descriptor |
| fault | output | 1 | Translation fault |
| faultCode | output | 2 | 0 none, 1 section fault, 2 page fault |

## Verification
The assertions assume that memory returns exactly one `memRvalid` for each accepted request, after the grant and never in the same cycle, and that no data arrives while no read is outstanding. They also assume that `walkStart` is asserted only while `walkBusy` is low. The bench's memory model grants requests after a programmable delay and answers one or more cycles later. The bench raises `walkStart` for a single cycle, only while idle, and waits for `walkDone` before it starts the next walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walkState_t;

  typedef enum logic [1:0] {
    SZ_SECTION = 2'd0, SZ_SUPER = 2'd1, SZ_SMALL = 2'd2, SZ_LARGE = 2'd3
  } mapSize_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_SECTION = 2'd1, FLT_PAGE = 2'd2
  } faultKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;    // capture va / base on start
    logic selL2Addr;   // address mux: second-level
    logic latchL1;     // capture first-level descriptor
    logic latchL2;     // capture second-level descriptor
    logic finishDis;   // finish with disabled-walk fault
    logic finishL1;    // finish from first-level descriptor
    logic finishL2;    // finish from second-level descriptor
  } ctlStrobe_t;

  // first-level decode results
  typedef struct packed {
    logic isSection;
    logic isTable;
    logic isSuper;
  } l1Kind_t;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int L1_IDX_W  = 12,
  parameter int L2_IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [VA_W-1:0]   va,
  input  logic [VA_W-1:0]   ttbBase,
  input  logic [31:0]       memRdata,
  output logic [31:0]       memAddr,
  output l1Kind_t           l1Kind,
  output logic [31:0]       rdataL1Peek,
  output logic [31:0]       paddr,
  output logic [1:0]        sizeCode,
  output logic [3:0]        domain,
  output logic [9:0]        attr,
  output logic              fault,
  output logic [1:0]        faultCode
);
  localparam int SECT_OFF_W  = VA_W - L1_IDX_W;          // 20
  localparam int SUPER_OFF_W = SECT_OFF_W + 4;           // 24
  localparam int TTB_HI_W    = VA_W - L1_IDX_W - 2;      // 18
  localparam int CT_HI_W     = VA_W - L2_IDX_W - 2;      // 22
  localparam int SMALL_OFF_W = SECT_OFF_W - L2_IDX_W;    // 12
  localparam int LARGE_OFF_W = SMALL_OFF_W + 4;          // 16

  logic [VA_W-1:0] vaQ, ttbQ;
  logic [31:0]     l1Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0;
      ttbQ <= '0;
      l1Q <= '0;
    end else begin
      if (stb.latchReq) begin
        vaQ  <= va;
        ttbQ <= ttbBase;
      end
      if (stb.latchL1) l1Q <= memRdata;
    end
  end

  // address generation
  logic [31:0] l1Addr, l2Addr;
  assign l1Addr = {ttbQ[VA_W-1 -: TTB_HI_W], vaQ[VA_W-1 -: L1_IDX_W], 2'b00};
  assign l2Addr = {l1Q[31 -: CT_HI_W], vaQ[SECT_OFF_W-1 -: L2_IDX_W], 2'b00};
  assign memAddr = stb.selL2Addr ? l2Addr : l1Addr;

  // first-level type decode on live read data
  always_comb begin
    l1Kind.isSection = (memRdata[1:0] == 2'b10);
    l1Kind.isTable   = (memRdata[1:0] == 2'b01);
    l1Kind.isSuper   = memRdata[18];
  end
  assign rdataL1Peek = memRdata;

  // result computation
  logic [31:0] resPa;
  logic [1:0]  resSize, resFlt;
  logic [9:0]  resAttr;
  logic [3:0]  resDom;

  always_comb begin
    resPa   = '0;
    resSize = SZ_SECTION;
    resFlt  = FLT_NONE;
    resAttr = memRdata[11:2];
    resDom  = memRdata[8:5];
    if (stb.finishDis) begin
      resFlt  = FLT_SECTION;
      resAttr = '0;
      resDom  = '0;
    end else if (stb.finishL1) begin
      if (memRdata[1:0] != 2'b10) begin
        resFlt = FLT_SECTION;
      end else if (memRdata[18]) begin
        resSize = SZ_SUPER;
        resPa   = {memRdata[31:SUPER_OFF_W], vaQ[SUPER_OFF_W-1:0]};
      end else begin
        resSize = SZ_SECTION;
        resPa   = {memRdata[31:SECT_OFF_W], vaQ[SECT_OFF_W-1:0]};
      end
    end else if (stb.finishL2) begin
      resDom = l1Q[8:5];
      case (memRdata[1:0])
        2'b00: resFlt = FLT_PAGE;
        2'b01: begin
          resSize = SZ_LARGE;
          resPa   = {memRdata[31:LARGE_OFF_W], vaQ[LARGE_OFF_W-1:0]};
        end
        default: begin
          resSize = SZ_SMALL;
          resPa   = {memRdata[31:SMALL_OFF_W], vaQ[SMALL_OFF_W-1:0]};
        end
      endcase
    end
  end

  logic finishAny;
  assign finishAny = stb.finishDis | stb.finishL1 | stb.finishL2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paddr <= '0;
      sizeCode <= '0;
      domain <= '0;
      attr <= '0;
      fault <= 1'b0;
      faultCode <= '0;
    end else if (finishAny) begin
      paddr     <= resPa;
      sizeCode  <= resSize;
      domain    <= resDom;
      attr      <= resAttr;
      fault     <= (resFlt != FLT_NONE);
      faultCode <= resFlt;
    end
  end
endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       walkStart,
  input  logic       walkDisable,
  input  logic       memGnt,
  input  logic       memRvalid,
  input  l1Kind_t    l1Kind,
  output ctlStrobe_t stb,
  output logic       memReq,
  output logic       walkBusy,
  output logic       walkDone
);
  walkState_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    stb    = '0;
    case (st)
      ST_IDLE: if (walkStart) begin
        stb.latchReq = 1'b1;
        if (walkDisable) begin
          stb.finishDis = 1'b1;
          stNext = ST_DONE;
        end else begin
          stNext = ST_L1_REQ;
        end
      end
      ST_L1_REQ: if (memGnt) stNext = ST_L1_WAIT;
      ST_L1_WAIT: if (memRvalid) begin
        if (l1Kind.isTable) begin
          stb.latchL1 = 1'b1;
          stNext = ST_L2_REQ;
        end else begin
          stb.finishL1 = 1'b1;
          stNext = ST_DONE;
        end
      end
      ST_L2_REQ: begin
        stb.selL2Addr = 1'b1;
        if (memGnt) stNext = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        stb.selL2Addr = 1'b1;
        if (memRvalid) begin
          stb.finishL2 = 1'b1;
          stNext = ST_DONE;
        end
      end
      ST_DONE: stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  assign memReq   = (st == ST_L1_REQ) || (st == ST_L2_REQ);
  assign walkDone = (st == ST_DONE);
  assign walkBusy = (st != ST_IDLE);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        walkStart,
  input  logic [31:0] va,
  input  logic [31:0] ttbBase,
  input  logic        walkDisable,
  output logic        walkBusy,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memGnt,
  input  logic        memRvalid,
  input  logic [31:0] memRdata,
  output logic        walkDone,
  output logic [31:0] paddr,
  output logic [1:0]  sizeCode,
  output logic [3:0]  domain,
  output logic [9:0]  attr,
  output logic        fault,
  output logic [1:0]  faultCode
);
  ctlStrobe_t  stb;
  l1Kind_t     l1Kind;
  logic [31:0] rdataPeek;

  ptw_control ctl_i (
    .clk, .rstN, .walkStart, .walkDisable, .memGnt, .memRvalid,
    .l1Kind, .stb, .memReq, .walkBusy, .walkDone
  );

  ptw_datapath #(.VA_W(VA_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)) dp_i (
    .clk, .rstN, .stb, .va, .ttbBase, .memRdata, .memAddr, .l1Kind,
    .rdataL1Peek(rdataPeek), .paddr, .sizeCode, .domain, .attr, .fault, .faultCode
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk,
  input logic        rstN,
  input logic        walkStart,
  input logic        walkDisable,
  input logic        walkBusy,
  input logic        memReq,
  input logic [31:0] memAddr,
  input logic        memGnt,
  input logic        walkDone,
  input logic        fault,
  input logic [1:0]  faultCode
);
  // R10: a pending request holds until granted
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr)));

  // R10: done never lasts longer than one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |=> !walkDone);

  // R9: a disabled start gives no request and a section fault
  a_r9_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (walkStart && !walkBusy && walkDisable) |=> (!memReq && walkDone));
  a_r9_fault: assert property (@(posedge clk) disable iff (!rstN)
    (walkStart && !walkBusy && walkDisable) |=> ##1 (fault && faultCode == 2'd1));

  // R8: the fault flag agrees with the fault code
  a_r8_fault_code: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |-> (fault == (faultCode != 2'd0)));

  // R1: idle never drives a request or done
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !walkBusy |-> (!memReq && !walkDone));
endmodule

bind ptw_top ptw_checker chk_i (
  .clk, .rstN, .walkStart, .walkDisable, .walkBusy, .memReq, .memAddr,
  .memGnt, .walkDone, .fault, .faultCode
);

// File: tb/ptw_top_tb_top.sv
`timescale 1ns/1ps
module ptw_top_tb_top;
  logic clk = 0;
  logic rstN = 0;
  logic walkStart = 0, walkDisable = 0;
  logic [31:0] va = 0, ttbBase = 0;
  logic walkBusy, memReq, memGnt = 0, memRvalid = 0;
  logic [31:0] memAddr, memRdata = 0;
  logic walkDone, fault;
  logic [31:0] paddr;
  logic [1:0] sizeCode, faultCode;
  logic [3:0] domain;
  logic [9:0] attr;

  int nChecks = 0, nFails = 0;
  int gntDelay = 0;
  int reqCount = 0;
  logic [31:0] seenAddr [0:1];
  logic [31:0] respData [0:1];

  always #10 clk = ~clk;

  ptw_top dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: grant after gntDelay cycles, answer next cycle
  initial begin
    forever begin
      @(negedge clk);
      if (memReq) begin
        for (int i = 0; i < gntDelay; i++) begin
          @(negedge clk);
          if (reqCount < 2) chk("R10 addr hold", memAddr, seenAddr[reqCount]);
        end
        if (reqCount < 2) seenAddr[reqCount] = memAddr;
        memGnt = 1;
        @(negedge clk);
        memGnt = 0;
        memRvalid = 1;
        memRdata = respData[reqCount < 2 ? reqCount : 1];
        reqCount++;
        @(negedge clk);
        memRvalid = 0;
        memRdata = 0;
      end
    end
  end

  // runs one walk, returns after done sampled
  task automatic walk(input logic [31:0] v, input logic [31:0] t, input logic dis,
                      input logic [31:0] d1, input logic [31:0] d2, input int dly);
    int doneCnt = 0;
    reqCount = 0;
    gntDelay = dly;
    respData[0] = d1; respData[1] = d2;
    seenAddr[0] = 'x; seenAddr[1] = 'x;
    if (dly > 0) begin
      // seed hold-check address with the first-level expectation
      seenAddr[0] = {t[31:14], v[31:20], 2'b00};
      seenAddr[1] = {d1[31:10], v[19:12], 2'b00};
    end
    @(negedge clk);
    va = v; ttbBase = t; walkDisable = dis; walkStart = 1;
    @(negedge clk);
    walkStart = 0;
    for (int i = 0; i < 40 && doneCnt == 0; i++) begin
      if (walkDone) doneCnt++;
      else @(negedge clk);
    end
    chk("R10 done seen", doneCnt, 1);
    @(negedge clk);
    chk("R10 done one cycle", walkDone, 0);
  endtask

  task automatic t_reset;
    chk("R1 reset done", walkDone, 0);
    chk("R1 reset req", memReq, 0);
    chk("R1 reset busy", walkBusy, 0);
  endtask

  task automatic t_section;
    walk(32'hABC12345, 32'h8000_4000, 0, 32'h30000C02 | (4'h5 << 5), 0, 0);
    chk("R2 l1 addr", seenAddr[0], {18'h20001, 12'hABC, 2'b00});
    chk("R3 paddr", paddr, 32'h30012345);
    chk("R3 size", sizeCode, 0);
    chk("R3 fault", faultCode, 0);
    chk("R11 domain", domain, 4'h5);
    chk("R11 attr", attr, 10'((32'h30000C02 | (4'h5 << 5)) >> 2));
    chk("R3 reads", reqCount, 1);
  endtask

  task automatic t_super;
    walk(32'h12345678, 32'h0000_C000, 0, 32'h7F040002, 0, 2);
    chk("R4 paddr", paddr, 32'h7F345678);
    chk("R4 size", sizeCode, 1);
    chk("R4 reads", reqCount, 1);
  endtask

  task automatic t_small;
    logic [31:0] d1 = 32'h00456C01 | (4'h9 << 5);
    walk(32'h0027A3BC, 32'h1000_0000, 0, d1, 32'hDEADB00E, 1);
    chk("R5 l2 addr", seenAddr[1], {d1[31:10], 8'h7A, 2'b00});
    chk("R6 paddr", paddr, 32'hDEADB3BC);
    chk("R6 size", sizeCode, 2);
    chk("R11 l2 domain", domain, 4'h9);
    chk("R11 l2 attr", attr, 10'(32'hDEADB00E >> 2));
    chk("R6 reads", reqCount, 2);
  endtask

  task automatic t_small11;
    walk(32'h0027A3BC, 32'h1000_0000, 0, 32'h00456C01, 32'h11111003, 0);
    chk("R6 type11 paddr", paddr, 32'h111113BC);
    chk("R6 type11 size", sizeCode, 2);
  endtask

  task automatic t_large;
    walk(32'h0033CDEF, 32'h0, 0, 32'h00100001, 32'hCAFE0001, 3);
    chk("R7 paddr", paddr, 32'hCAFECDEF);
    chk("R7 size", sizeCode, 3);
  endtask

  task automatic t_faults;
    walk(32'h11111111, 32'h0, 0, 32'h12345600, 0, 0);
    chk("R8 l1 00 fault", {fault, faultCode}, 3'b101);
    walk(32'h11111111, 32'h0, 0, 32'h12345603, 0, 0);
    chk("R8 l1 11 fault", {fault, faultCode}, 3'b101);
    chk("R8 l1 11 reads", reqCount, 1);
    walk(32'h11111111, 32'h0, 0, 32'h00100001, 32'hFFFFF000, 0);
    chk("R8 l2 fault", {fault, faultCode}, 3'b110);
    walk(32'h11111111, 32'h0, 0, 32'h00100002, 0, 0);
    chk("R8 no fault", {fault, faultCode}, 3'b000);
  endtask

  task automatic t_disable;
    walk(32'h11111111, 32'h0, 1, 32'h00100002, 0, 0);
    chk("R9 no reads", reqCount, 0);
    chk("R9 fault", {fault, faultCode}, 3'b101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_section();
    t_super();
    t_small();
    t_small11();
    t_large();
    t_faults();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule